// File: doc/BRIEF.md
# Two-Core Cluster Reset and Boot Register Block

This block is a bank of 32-bit registers on a word-addressed bus that governs the resets and power state of a two-core processor cluster. Software writes a core-reset control word to put either core through reset, and toggles an enable bit to start or stop the secondary core. Side effects follow only the bits a write actually flips: the block XORs the stored word with the written word, and the new word is always stored.

A reset request is a handshake. The block pulses a request to the core and keeps that core's reset bit set as written. The bit clears itself only after the core raises its done acknowledge. Starting the secondary core pulses a power-on request. It also hands the core a start address and an argument, both taken from two general-purpose registers. Stopping it pulses a power-off request. A start or a stop also arms the self-clear of core 1's reset bit.

The register map holds 23 words. In index order these are: control, core-reset control 0, core-reset control 1, auxiliary reset, external reset, three PHY reset words, boot mode 1, reset status, interrupt status, interrupt mask, boot mode 2, and general-purpose words 1 to 10. Index 1 and index 2 are the only words with side effects. All other words simply store what is written.

Top module: `cluster_rst_regs`

## Requirements
- R1: After reset, index 0 reads 0x000000A0, index 9 reads 0x00000001, index 11 reads 0x0000001F, and every other index reads zero. All request outputs, the boot address and the boot argument are low.
- R2: The word index is `bus_addr[11:2]`, and `bus_addr[1:0]` is ignored. `bus_rdata` shows the addressed word without delay, and any index of 23 or more reads zero.
- R3: A write (`bus_sel` and `bus_we` high at a clock edge) stores the full word at any index below 23. During the write cycle, `bus_rdata` still shows the value held before the write.
- R4: A write at index 23 or above changes no register and raises no request.
- R5: A write to index 1 that flips bit 0 pulses `core_rst_req[0]` high for exactly the cycle after the write edge. Flipping bit 1 does the same on `core_rst_req[1]`. A bit written with its current value gives no pulse.
- R6: After a reset request, the reset bit of index 1 keeps its written value until that core's `core_rst_done` is sampled high. From the next cycle it reads 0, and the other bits are untouched.
- R7: `core_rst_done` for a core with nothing pending is ignored. It clears no bit, and it does not pre-clear a later request.
- R8: A write to index 2 that flips bit 1 from 0 to 1 pulses `c1_on_req` for one cycle. In the same cycle `c1_boot_addr` and `c1_boot_arg` load index 15 and index 16 as held before the edge. They keep those values until the next power-on.
- R9: A write to index 2 that flips bit 1 from 1 to 0 pulses `c1_off_req` for one cycle. Changes to other bits of index 2 give no pulse.
- R10: Flipping bit 1 of index 2 raises no `core_rst_req[1]`. It does leave core 1 pending, so a later `core_rst_done[1]` clears bit 1 of index 1.
- R11: A new reset request for a core whose request is still pending pulses the request again. One done acknowledge then clears the pending state.
- R12: When a write to index 1 and a self-clear hit the same edge, the written word is stored first and the self-clear then forces the acknowledged bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 12 | Byte address inside the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core_rst_req | output | 2 | Per-core one-cycle reset request |
| core_rst_done | input | 2 | Per-core reset/transition complete |
| c1_on_req | output | 1 | One-cycle power-on request to core 1 |
| c1_off_req | output | 1 | One-cycle power-off request to core 1 |
| c1_boot_addr | output | 32 | Start address for core 1 |
| c1_boot_arg | output | 32 | Boot argument for core 1 |

## Verification
The whole 1024-word window is swept twice, once for reset values and once after writing a distinct word to every index, with sub-word address bits set. This separates the defined words from the zero-reading holes and shows that out-of-range writes land nowhere. Index 1 is written with patterns that flip one bit, both bits, or no bit. This separates change-triggered pulses from level-triggered ones. Done pulses are placed in three spots: with nothing pending, while pending, and on the same edge as a write. These placements separate a latched pending flag from a raw acknowledge, and show the clear applied after the write. The enable bit of index 2 is toggled up and down and written alongside other bit changes. General-purpose word 3 is changed between power-ons, which shows the start address is captured at power-on.

// File: rtl/crst_pkg.sv
package crst_pkg;

  localparam int WORD_W    = 32;
  localparam int REG_COUNT = 23;
  localparam int CORES     = 2;

  // Register indices whose behaviour the logic depends on
  localparam int IDX_CTRL  = 0;
  localparam int IDX_CRC0  = 1;
  localparam int IDX_CRC1  = 2;
  localparam int IDX_STAT  = 9;
  localparam int IDX_IMASK = 11;
  localparam int IDX_GP3   = 15;
  localparam int IDX_GP4   = 16;

  // Bit of index 2 that enables core 1
  localparam int C1_EN_BIT = 1;
  localparam int C1_ID     = 1;

  localparam logic [WORD_W-1:0] CTRL_INIT  = 32'h0000_00A0;
  localparam logic [WORD_W-1:0] STAT_INIT  = 32'h0000_0001;
  localparam logic [WORD_W-1:0] IMASK_INIT = 32'h0000_001F;

  function automatic logic [WORD_W-1:0] reset_word(input int idx);
    case (idx)
      IDX_CTRL:  return CTRL_INIT;
      IDX_STAT:  return STAT_INIT;
      IDX_IMASK: return IMASK_INIT;
      default:   return '0;
    endcase
  endfunction

  // One bit of an XOR change mask
  function automatic logic flipped(input logic held, input logic wr);
    return held ^ wr;
  endfunction

  // Force acknowledged reset bits to zero after the write has been merged
  function automatic logic [WORD_W-1:0] drop_done_bits(input logic [WORD_W-1:0] w,
                                                       input logic [CORES-1:0] clr);
    return w & ~{{(WORD_W-CORES){1'b0}}, clr};
  endfunction

endpackage

// File: rtl/crst_regbank.sv
module crst_regbank #(
  parameter int NUM_REGS = crst_pkg::REG_COUNT,
  parameter int IDX_W    = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_req,
  input  logic [IDX_W-1:0]              acc_idx,
  input  logic [crst_pkg::WORD_W-1:0]   wr_data,
  input  logic [crst_pkg::CORES-1:0]    clr_mask,
  output logic                          wr_hit,
  output logic [crst_pkg::WORD_W-1:0]   rd_data,
  output logic [crst_pkg::CORES-1:0]    rst_bits_q,
  output logic                          en_bit_q,
  output logic [crst_pkg::WORD_W-1:0]   gp3_q,
  output logic [crst_pkg::WORD_W-1:0]   gp4_q
);
  import crst_pkg::*;

  localparam int SEL_W = $clog2(NUM_REGS);
  localparam int SLOTS = 1 << SEL_W;

  logic [WORD_W-1:0]          bank [SLOTS];
  logic [NUM_REGS*WORD_W-1:0] flat;
  logic                       in_range;

  assign in_range = acc_idx < IDX_W'(NUM_REGS);
  assign wr_hit   = wr_req && in_range;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_REGS) begin : g_live
      logic [WORD_W-1:0] q;
      logic [WORD_W-1:0] d;
      always_comb begin
        d = q;
        if (wr_hit && acc_idx == IDX_W'(g)) d = wr_data;
        if (g == IDX_CRC0) d = drop_done_bits(d, clr_mask);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reset_word(g);
        else        q <= d;
      end
      assign bank[g] = q;
      assign flat[g*WORD_W +: WORD_W] = q;
    end else begin : g_hole
      assign bank[g] = '0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (in_range) rd_data = bank[acc_idx[SEL_W-1:0]];
  end

  assign rst_bits_q = bank[IDX_CRC0][CORES-1:0];
  assign en_bit_q   = bank[IDX_CRC1][C1_EN_BIT];
  assign gp3_q      = bank[IDX_GP3];
  assign gp4_q      = bank[IDX_GP4];

  // R4: a write outside the map, with no self-clear, leaves every word alone
  assert_miss_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_hit && clr_mask == '0) |=> $stable(flat));

endmodule

// File: rtl/crst_core_hs.sv
module crst_core_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_trig,
  input  logic pwr_trig,
  input  logic done,
  output logic rst_req,
  output logic pending,
  output logic clr
);

  // Self-clear fires only while a request is outstanding
  assign clr = pending && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      pending <= 1'b0;
    end else begin
      rst_req <= rst_trig;
      pending <= (pending && !done) || rst_trig || pwr_trig;
    end
  end

  // R5: every request pulse is backed by a pending flag
  assert_req_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> pending);

  // R7: with nothing pending and no new trigger, nothing becomes pending
  assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !rst_trig && !pwr_trig) |=> !pending);

endmodule

// File: rtl/crst_c1_launch.sv
module crst_c1_launch (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_trig,
  input  logic                        en_level,
  input  logic [crst_pkg::WORD_W-1:0] gp3,
  input  logic [crst_pkg::WORD_W-1:0] gp4,
  output logic                        on_req,
  output logic                        off_req,
  output logic [crst_pkg::WORD_W-1:0] boot_addr,
  output logic [crst_pkg::WORD_W-1:0] boot_arg
);

  logic start_now;
  assign start_now = en_trig && en_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_req    <= 1'b0;
      off_req   <= 1'b0;
      boot_addr <= '0;
      boot_arg  <= '0;
    end else begin
      on_req  <= start_now;
      off_req <= en_trig && !en_level;
      if (start_now) begin
        boot_addr <= gp3;
        boot_arg  <= gp4;
      end
    end
  end

  // R9: on and off never pulse together
  assert_onoff_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(on_req && off_req));

  // R8: the handed-over address and argument are the words held before the edge
  assert_boot_words_R8: assert property (@(posedge clk) disable iff (!rst_n)
    on_req |-> (boot_addr == $past(gp3) && boot_arg == $past(gp4)));

endmodule

// File: rtl/cluster_rst_regs.sv
module cluster_rst_regs #(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = crst_pkg::REG_COUNT
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [crst_pkg::WORD_W-1:0] bus_wdata,
  output logic [crst_pkg::WORD_W-1:0] bus_rdata,
  output logic [crst_pkg::CORES-1:0]  core_rst_req,
  input  logic [crst_pkg::CORES-1:0]  core_rst_done,
  output logic                        c1_on_req,
  output logic                        c1_off_req,
  output logic [crst_pkg::WORD_W-1:0] c1_boot_addr,
  output logic [crst_pkg::WORD_W-1:0] c1_boot_arg
);
  import crst_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  // Named internal events
  logic              wr_req;
  logic              wr_hit;
  logic [IDX_W-1:0]  acc_idx;
  logic [CORES-1:0]  rst_bits_q;
  logic              en_bit_q;
  logic [WORD_W-1:0] gp3_q;
  logic [WORD_W-1:0] gp4_q;
  logic [CORES-1:0]  rst_trig;
  logic              en_trig;
  logic [CORES-1:0]  pending;
  logic [CORES-1:0]  clr;
  logic              hit_crc0;
  logic              hit_crc1;

  assign wr_req   = bus_sel && bus_we;
  assign acc_idx  = IDX_W'(bus_addr >> 2);
  assign hit_crc0 = wr_hit && acc_idx == IDX_W'(IDX_CRC0);
  assign hit_crc1 = wr_hit && acc_idx == IDX_W'(IDX_CRC1);
  assign en_trig  = hit_crc1 && flipped(en_bit_q, bus_wdata[C1_EN_BIT]);

  crst_regbank #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (wr_req),
    .acc_idx    (acc_idx),
    .wr_data    (bus_wdata),
    .clr_mask   (clr),
    .wr_hit     (wr_hit),
    .rd_data    (bus_rdata),
    .rst_bits_q (rst_bits_q),
    .en_bit_q   (en_bit_q),
    .gp3_q      (gp3_q),
    .gp4_q      (gp4_q)
  );

  for (genvar c = 0; c < CORES; c++) begin : g_core
    logic pwr_trig;
    assign rst_trig[c] = hit_crc0 && flipped(rst_bits_q[c], bus_wdata[c]);
    if (c == C1_ID) begin : g_sec
      assign pwr_trig = en_trig;
    end else begin : g_pri
      assign pwr_trig = 1'b0;
    end

    crst_core_hs u_hs (
      .clk      (clk),
      .rst_n    (rst_n),
      .rst_trig (rst_trig[c]),
      .pwr_trig (pwr_trig),
      .done     (core_rst_done[c]),
      .rst_req  (core_rst_req[c]),
      .pending  (pending[c]),
      .clr      (clr[c])
    );

    // R6: an accepted acknowledge leaves the stored reset bit at zero
    assert_clear_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr[c] |=> (rst_bits_q[c] == 1'b0));
  end

  crst_c1_launch u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_trig   (en_trig),
    .en_level  (bus_wdata[C1_EN_BIT]),
    .gp3       (gp3_q),
    .gp4       (gp4_q),
    .on_req    (c1_on_req),
    .off_req   (c1_off_req),
    .boot_addr (c1_boot_addr),
    .boot_arg  (c1_boot_arg)
  );

  // R10: an enable flip never raises a reset request for core 1
  assert_en_no_rst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_trig |=> !core_rst_req[C1_ID]);

endmodule

// File: tb/test_cluster_rst_regs.sv
module test_cluster_rst_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  core_rst_req;
  logic [1:0]  core_rst_done = '0;
  logic        c1_on_req, c1_off_req;
  logic [31:0] c1_boot_addr, c1_boot_arg;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [31:0] mdl [23];

  always #4 clk = ~clk;

  cluster_rst_regs i_cluster_rst_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_rst_req(core_rst_req), .core_rst_done(core_rst_done),
    .c1_on_req(c1_on_req), .c1_off_req(c1_off_req),
    .c1_boot_addr(c1_boot_addr), .c1_boot_arg(c1_boot_arg)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] expect_rd(input int i);
    return (i < 23) ? mdl[i] : 32'h0;
  endfunction

  function automatic logic [31:0] pat(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ (i << 7);
  endfunction

  function automatic logic [11:0] byte_addr(input int i);
    return 12'((i << 2) | (i & 3));
  endfunction

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic [1:0] dn, output logic [31:0] pre);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; core_rst_done = dn;
    #1 pre = bus_rdata;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0; core_rst_done = '0;
  endtask

  task automatic ack(input logic [1:0] dn);
    @(negedge clk);
    core_rst_done = dn;
    @(posedge clk);
    #1 core_rst_done = '0;
  endtask

  task automatic pulses(input string tag, input logic [1:0] rq, input logic on, input logic off);
    chk(tag, {28'h0, core_rst_req, c1_on_req, c1_off_req}, {28'h0, rq, on, off});
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, pre;
    for (int i = 0; i < 23; i++)
      mdl[i] = (i == 0) ? 32'hA0 : (i == 9) ? 32'h1 : (i == 11) ? 32'h1F : 32'h0;

    idle(3);
    pulses("R1 outputs in reset", 2'b00, 1'b0, 1'b0);
    chk("R1 boot addr in reset", c1_boot_addr, 32'h0);
    chk("R1 boot arg in reset", c1_boot_arg, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // R1/R2: reset sweep of the whole window
    for (int i = 0; i < 1024; i++) begin
      rd(byte_addr(i), v);
      chk((i < 23) ? "R1 reset value" : "R2 hole reads zero", v, expect_rd(i));
    end

    // R3/R4: write every index except the two side-effect words
    for (int i = 0; i < 1024; i++) begin
      if (i == 1 || i == 2) continue;
      wr(byte_addr(i), pat(i), 2'b00, pre);
      chk("R3 pre-write read", pre, expect_rd(i));
      pulses("R4 no side effect", 2'b00, 1'b0, 1'b0);
      if (i < 23) mdl[i] = pat(i);
    end
    for (int i = 0; i < 1024; i++) begin
      rd(byte_addr(i), v);
      chk((i < 23) ? "R3 stored word" : "R4 ignored write", v, expect_rd(i));
    end

    // R7: acknowledge with nothing pending
    ack(2'b11);
    rd(12'h004, v); chk("R7 idle ack", v, 32'h0);
    pulses("R7 no pulse", 2'b00, 1'b0, 1'b0);

    // R5/R6: single-bit flip and handshake
    wr(12'h004, 32'hA5A5_0001, 2'b00, pre);
    pulses("R5 core0 pulse", 2'b01, 1'b0, 1'b0);
    idle(1);
    pulses("R5 pulse width", 2'b00, 1'b0, 1'b0);
    rd(12'h004, v); chk("R6 held as written", v, 32'hA5A5_0001);
    idle(3);
    rd(12'h004, v); chk("R6 still held", v, 32'hA5A5_0001);
    ack(2'b10);
    rd(12'h004, v); chk("R7 other core ack ignored", v, 32'hA5A5_0001);
    ack(2'b01);
    rd(12'h004, v); chk("R6 self-clear", v, 32'hA5A5_0000);
    wr(12'h004, 32'hA5A5_0000, 2'b00, pre);
    pulses("R5 unchanged bits", 2'b00, 1'b0, 1'b0);

    // R11: re-request while pending
    wr(12'h004, 32'hA5A5_0003, 2'b00, pre);
    pulses("R5 both cores", 2'b11, 1'b0, 1'b0);
    wr(12'h004, 32'hA5A5_0000, 2'b00, pre);
    pulses("R11 re-pulse", 2'b11, 1'b0, 1'b0);
    wr(12'h004, 32'hA5A5_0003, 2'b00, pre);
    pulses("R11 re-pulse again", 2'b11, 1'b0, 1'b0);
    rd(12'h004, v); chk("R11 held", v, 32'hA5A5_0003);
    ack(2'b11);
    rd(12'h004, v); chk("R11 one ack clears", v, 32'hA5A5_0000);
    wr(12'h004, 32'hA5A5_0003, 2'b00, pre);
    rd(12'h004, v); chk("R7 no stale clear", v, 32'hA5A5_0003);
    ack(2'b11);
    rd(12'h004, v); chk("R6 clear both", v, 32'hA5A5_0000);

    // R12: write and self-clear on one edge
    wr(12'h004, 32'h0000_00F1, 2'b00, pre);
    pulses("R5 core0 again", 2'b01, 1'b0, 1'b0);
    wr(12'h004, 32'h0000_00F1, 2'b01, pre);
    chk("R3 pre-write value", pre, 32'h0000_00F1);
    pulses("R12 no new pulse", 2'b00, 1'b0, 1'b0);
    rd(12'h004, v); chk("R12 clear after write", v, 32'h0000_00F0);

    // R8-R10: core 1 enable
    wr(12'h03C, 32'h8000_1000, 2'b00, pre);
    wr(12'h040, 32'h0000_BEEF, 2'b00, pre);
    wr(12'h004, 32'h0000_00F2, 2'b10, pre);
    pulses("R5 core1 pulse", 2'b10, 1'b0, 1'b0);
    rd(12'h004, v); chk("R7 ack before pending", v, 32'h0000_00F2);
    ack(2'b10);
    rd(12'h004, v); chk("R6 core1 clear", v, 32'h0000_00F0);

    wr(12'h008, 32'h0000_0002, 2'b00, pre);
    pulses("R10 on without reset", 2'b00, 1'b1, 1'b0);
    chk("R8 boot addr", c1_boot_addr, 32'h8000_1000);
    chk("R8 boot arg", c1_boot_arg, 32'h0000_BEEF);
    idle(1);
    pulses("R8 on width", 2'b00, 1'b0, 1'b0);
    rd(12'h008, v); chk("R3 enable stored", v, 32'h0000_0002);
    wr(12'h004, 32'h0000_00F2, 2'b10, pre);
    rd(12'h004, v); chk("R10 enable armed clear", v, 32'h0000_00F0);
    ack(2'b10);

    wr(12'h03C, 32'h1234_5678, 2'b00, pre);
    chk("R8 addr held", c1_boot_addr, 32'h8000_1000);
    wr(12'h008, 32'h0000_0000, 2'b00, pre);
    pulses("R9 off pulse", 2'b00, 1'b0, 1'b1);
    chk("R8 addr kept on off", c1_boot_addr, 32'h8000_1000);
    ack(2'b10);
    wr(12'h008, 32'h0000_0005, 2'b00, pre);
    pulses("R9 other bits", 2'b00, 1'b0, 1'b0);
    wr(12'h008, 32'h0000_0007, 2'b00, pre);
    pulses("R8 on again", 2'b00, 1'b1, 1'b0);
    chk("R8 new addr", c1_boot_addr, 32'h1234_5678);
    chk("R8 arg again", c1_boot_arg, 32'h0000_BEEF);
    ack(2'b10);
    rd(12'h004, v); chk("R6 final word", v, 32'h0000_00F0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule